// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches 23 asynchronous input lines. It turns the edges that software selects on them into latched interrupt requests and single-cycle event pulses. Each line is synchronised and then edge-detected. Each line then has its own choice of rising, falling, both or no edges. A detected trigger sets a sticky pending bit and may also emit an event pulse. Interrupt and event masking are independent of each other.

Software reaches six 32-bit registers through a simple write-strobe bus with combinational read data. The registers are:

- interrupt enable, at byte offset 0x00
- event enable, at 0x04
- rising-edge enable, at 0x08
- falling-edge enable, at 0x0C
- software trigger, at 0x10
- pending, at 0x14

Register bit *i* belongs to line *i*. Software can also force a trigger on any line without an edge. Software acknowledges a pending bit by writing 1 to it.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq_line`, `evt_line` and `irq_any` are low.
- R2: The registers decode from `addr[4:2]`, which selects one of the six registers in the order of their byte offsets. Only bits 22..0 exist. Bits 31..23 read zero and ignore writes. Unmapped offsets read zero.
- R3: `irq_line[i]` is high exactly when pending bit i and interrupt-enable bit i are both 1. Clearing the enable hides a pending line without clearing it.
- R4: An event pulse on line i requires event-enable bit i. With it cleared, a trigger still sets pending but `evt_line[i]` stays low.
- R5: With rising-enable bit i set, a 0-to-1 change on `line_in[i]` is a trigger.
- R6: With falling-enable bit i set, a 1-to-0 change on `line_in[i]` is a trigger. With both enables set, either edge triggers. With neither set, the line never triggers from its input.
- R7: A change on `line_in` that is first sampled at clock edge k sets the pending bit and the event output at edge k+2, not earlier.
- R8: Writing 1 to a software-trigger bit sets that bit and the matching pending bit at the write edge. It also pulses the event output if the event is enabled. Writing 0 to a software-trigger bit has no effect.
- R9: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. A trigger at the same edge as the clear keeps the bit set.
- R10: A software-trigger bit returns to 0 when its pending bit is cleared by a write.
- R11: `evt_line[i]` is a one-cycle pulse for each trigger. It fires even when the pending bit is already set.
- R12: `irq_any` is the OR of all bits of `irq_line`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 23 | Asynchronous external request lines |
| we | input | 1 | Register write strobe, sampled on the clock edge |
| addr | input | 5 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_line | output | 23 | Per-line interrupt request |
| evt_line | output | 23 | Per-line one-cycle event pulse |
| irq_any | output | 1 | Combined interrupt request |

## Verification
The acknowledge write to the pending register can land on the same clock edge as a fresh trigger on that line. The bench provokes this by dropping a line with falling detection enabled and timing the clearing write to hit the edge at which the synchronised edge arrives. It then expects the pending bit to survive together with an event pulse. A software-trigger write and a pending clear are also driven in the same cycle during the random phase. There, a behavioural model that updates once per clock is compared on every cycle against all outputs and the register being read.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int N = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  input  logic         we,
  input  logic [4:0]   addr,
  input  logic [31:0]  wdata,
  output logic [31:0]  rdata,
  output logic [N-1:0] irq_line,
  output logic [N-1:0] evt_line,
  output logic         irq_any
);
  localparam int PAD = 32 - N;
  localparam logic [2:0] A_IE = 3'd0, A_EE = 3'd1, A_RE = 3'd2,
                         A_FE = 3'd3, A_SW = 3'd4, A_PD = 3'd5;

  logic [N-1:0] ie, ee, re, fe, swt, pend;
  logic [N-1:0] s1, s2, s3, evt_q;
  logic [N-1:0] wv, sw_set, clr, trig, rsel;
  logic [2:0]   idx;
  logic         unused_bits;

  assign idx         = addr[4:2];
  assign wv          = wdata[N-1:0];
  assign unused_bits = ^{wdata[31:N], addr[1:0]};
  assign sw_set      = (we && idx == A_SW) ? wv : '0;
  assign clr         = (we && idx == A_PD) ? wv : '0;
  assign trig        = (re & s2 & ~s3) | (fe & ~s2 & s3) | sw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      {ie, ee, re, fe, swt, pend, evt_q} <= '0;
    end else begin
      s1    <= line_in;
      s2    <= s1;
      s3    <= s2;
      pend  <= (pend & ~clr) | trig;
      swt   <= (swt & ~clr) | sw_set;
      evt_q <= trig & ee;
      if (we) begin
        case (idx)
          A_IE: ie <= wv;
          A_EE: ee <= wv;
          A_RE: re <= wv;
          A_FE: fe <= wv;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      A_IE:    rsel = ie;
      A_EE:    rsel = ee;
      A_RE:    rsel = re;
      A_FE:    rsel = fe;
      A_SW:    rsel = swt;
      A_PD:    rsel = pend;
      default: rsel = '0;
    endcase
  end

  assign rdata    = {{PAD{1'b0}}, rsel};
  assign irq_line = pend & ie;
  assign evt_line = evt_q;
  assign irq_any  = |irq_line;

  p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((pend & $past(clr & ~trig)) == '0));
  p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~pend & ~$past(clr)) == '0));
  p_evt_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(ee)) == '0));
  p_evt_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~pend) == '0);
  p_swt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr & ~sw_set) & swt) == '0));
  p_pend_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(trig)) == '0));
endmodule

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] line_in = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [22:0] irq_line, evt_line;
  logic        irq_any;

  int errors = 0;
  int checks = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_line(irq_line), .evt_line(evt_line),
    .irq_any(irq_any)
  );

  always #10 clk = ~clk;

  // behavioural reference
  logic [22:0] m_ie = '0, m_ee = '0, m_re = '0, m_fe = '0, m_sw = '0, m_pd = '0, m_ev = '0;
  logic [22:0] h0 = '0, h1 = '0, h2 = '0;

  always @(posedge clk) begin
    logic [22:0] sws, cl, tg;
    if (!rst_n) begin
      {m_ie, m_ee, m_re, m_fe, m_sw, m_pd, m_ev} = '0;
      {h0, h1, h2} = '0;
    end else begin
      sws = (we && addr[4:2] == 3'd4) ? wdata[22:0] : 23'd0;
      cl  = (we && addr[4:2] == 3'd5) ? wdata[22:0] : 23'd0;
      tg  = (m_re & h1 & ~h2) | (m_fe & ~h1 & h2) | sws;
      m_ev = tg & m_ee;
      m_pd = (m_pd & ~cl) | tg;
      m_sw = (m_sw & ~cl) | sws;
      if (we) begin
        case (addr[4:2])
          3'd0: m_ie = wdata[22:0];
          3'd1: m_ee = wdata[22:0];
          3'd2: m_re = wdata[22:0];
          3'd3: m_fe = wdata[22:0];
          default: ;
        endcase
      end
      h2 = h1; h1 = h0; h0 = line_in;
    end
    started = 1'b1;
  end

  function automatic logic [31:0] model_read(input logic [2:0] i);
    case (i)
      3'd0: return {9'd0, m_ie};
      3'd1: return {9'd0, m_ee};
      3'd2: return {9'd0, m_re};
      3'd3: return {9'd0, m_fe};
      3'd4: return {9'd0, m_sw};
      3'd5: return {9'd0, m_pd};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] i);
    case (i)
      3'd0, 3'd1: return "R2 enable readback";
      3'd2: return "R5 rise_en readback";
      3'd3: return "R6 fall_en readback";
      3'd4: return "R10 sw_trig readback";
      3'd5: return "R9 pending readback";
      default: return "R2 unmapped readback";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3 irq_line", {9'd0, irq_line}, {9'd0, m_pd & m_ie});
      chk("R4 evt_line", {9'd0, evt_line}, {9'd0, m_ev});
      chk("R12 irq_any", {31'd0, irq_any}, {31'd0, |(m_pd & m_ie)});
      chk(read_tag(addr[4:2]), rdata, model_read(addr[4:2]));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    for (int a = 0; a < 6; a++) rd_chk("R1 reset register", 5'(a * 4), 32'd0);
    chk("R1 reset irq_any", {31'd0, irq_any}, 32'd0);
    chk("R1 reset evt_line", {9'd0, evt_line}, 32'd0);

    wr(5'h00, 32'hFFFF_FFFF);
    rd_chk("R2 upper bits", 5'h00, 32'h007F_FFFF);
    wr(5'h04, 32'h007F_FFFF);
    wr(5'h08, 32'h0000_0005);
    wr(5'h0C, 32'h0000_0006);
    rd_chk("R2 fall_en offset", 5'h0C, 32'h0000_0006);

    addr = 5'h14;
    line_in[0] = 1'b1;
    step(); step();
    rd_chk("R7 not yet pending", 5'h14, 32'd0);
    step();
    rd_chk("R5 rising pending", 5'h14, 32'h1);
    chk("R11 event pulse", {9'd0, evt_line}, 32'h1);
    chk("R3 irq asserted", {9'd0, irq_line}, 32'h1);
    step();
    chk("R11 pulse one cycle", {9'd0, evt_line}, 32'd0);

    line_in[1] = 1'b1;
    repeat (4) step();
    rd_chk("R6 rise ignored on fall-only", 5'h14, 32'h1);
    line_in[1] = 1'b0;
    repeat (3) step();
    rd_chk("R6 falling pending", 5'h14, 32'h3);
    line_in[3] = 1'b1;
    repeat (4) step();
    line_in[3] = 1'b0;
    repeat (4) step();
    rd_chk("R6 no edge enable", 5'h14, 32'h3);

    line_in[2] = 1'b1;
    repeat (3) step();
    rd_chk("R6 both edges rise", 5'h14, 32'h7);
    wr(5'h14, 32'h4);
    rd_chk("R9 write one clears", 5'h14, 32'h3);
    wr(5'h14, 32'h0);
    rd_chk("R9 write zero no effect", 5'h14, 32'h3);
    line_in[2] = 1'b0;
    step(); step();
    wr(5'h14, 32'h4);
    rd_chk("R9 trigger beats clear", 5'h14, 32'h7);
    chk("R6 both edges fall event", {9'd0, evt_line}, 32'h4);

    wr(5'h14, 32'h007F_FFFF);
    rd_chk("R9 clear all", 5'h14, 32'd0);
    wr(5'h10, 32'h20);
    rd_chk("R8 sw trigger pending", 5'h14, 32'h20);
    chk("R8 sw trigger event", {9'd0, evt_line}, 32'h20);
    rd_chk("R8 sw trigger readback", 5'h10, 32'h20);
    wr(5'h10, 32'h0);
    rd_chk("R8 write zero no effect", 5'h10, 32'h20);
    wr(5'h14, 32'h20);
    rd_chk("R10 sw bit self clears", 5'h10, 32'd0);

    wr(5'h04, 32'h0);
    line_in[0] = 1'b0;
    repeat (3) step();
    addr = 5'h14;
    line_in[0] = 1'b1;
    repeat (3) step();
    chk("R4 event masked", {9'd0, evt_line}, 32'd0);
    rd_chk("R4 pending still set", 5'h14, 32'h1);

    wr(5'h00, 32'h0);
    chk("R3 masked irq_line", {9'd0, irq_line}, 32'd0);
    chk("R12 masked irq_any", {31'd0, irq_any}, 32'd0);
    wr(5'h00, 32'h1);
    chk("R12 irq_any on", {31'd0, irq_any}, 32'h1);

    wr(5'h04, 32'h007F_FFFF);
    wr(5'h14, 32'h1);
    step();
    wr(5'h14, 32'h1);
    rd_chk("R11 event while pending", 5'h14, 32'h0);
    wr(5'h10, 32'h1);
    wr(5'h10, 32'h1);
    chk("R11 event with pending set", {9'd0, evt_line}, 32'h1);

    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r;
      r = $urandom;
      line_in = line_in ^ (23'(r) & 23'(r >> 9) & 23'(r >> 4));
      if (r[31:29] == 3'd0)
        wr({r[28:26] % 3'd6, 2'b00}, $urandom);
      else if (r[31:29] == 3'd1)
        wr(5'h14, $urandom);
      else begin
        addr = {r[28:26], r[1:0]};
        step();
      end
    end
    step();
    finish_run();
  end
endmodule